// File: doc/BRIEF.md
# Power Delivery Receive Filter and Acknowledge Generator

This block sits after a Power Delivery physical-layer receiver. The receiver reports three things: the kind of start-of-packet ordered set it found, the 16-bit message header, and the end of the message together with an error flag. When a message ends cleanly, the block decides whether to pass it up to the protocol layer. It also decides whether to build the automatic acknowledge (GoodCRC) reply header and ask the transmitter to send it.

An incoming acknowledge is handled on its own path and is never delivered upward. Instead it produces a one-cycle event and stores its message ID, so the transmit side can match it against the message it is waiting on. Messages that arrive on the cable-plug start-of-packet kinds are accepted only when that reception is enabled. A test mode keeps the acknowledge but stops delivery. A busy flag tells the transmitter that a reception is in progress.

Ordered-set codes on `sof_type` are 0 for SOP, 1 for SOP', 2 for SOP'', 3 for SOP' debug and 4 for SOP'' debug. Any other code is treated as a non-SOP kind.

Top module: `pd_rx_ack_filter`

## Requirements
- R1: A received header is an acknowledge when bit 15 (extended) is 0, bits 14:12 (object count) are 0 and bits 4:0 (message type) equal 5'b00001. A clean acknowledge pulses `ack_seen` and loads bits 11:9 into `ack_seen_id`, which holds its value until the next acknowledge. It raises neither `ack_req` nor `deliver_valid`, whatever the ordered-set kind.
- R2: The reply header built for `ack_req` has bit 15 = 0, bits 14:12 = 0 and bits 4:0 = 5'b00001. It copies bits 11:9 (message ID) and bits 7:6 (revision) from the received header.
- R3: In the reply header, bit 8 equals `cfg_power_role` and bit 5 equals `cfg_data_role` only when the received ordered set was SOP (code 0). For every other code, both bits are 0.
- R4: `ack_type` carries the received ordered-set code, and `ack_len` is 2 (header only).
- R5: A clean non-acknowledge message is accepted when its ordered-set code is 0 or `cfg_prime_en` is 1. An accepted message pulses `ack_req`, and also `deliver_valid` with `deliver_type` and `deliver_hdr` (the full received header). A rejected message produces neither pulse.
- R6: While `cfg_bist_mode` is 1, an accepted message still pulses `ack_req` but does not pulse `deliver_valid`.
- R7: A message whose `eom` arrives with `eom_err` = 1 produces no `ack_req`, no `deliver_valid` and no `ack_seen`, and leaves `ack_seen_id` unchanged.
- R8: `rx_active` becomes 1 in the cycle after `sof_valid`. It returns to 0 in the cycle after `eom`, unless `sof_valid` is high in that same cycle.
- R9: All result pulses appear exactly one cycle after the `eom` cycle and last one cycle per message. A header given with `hdr_valid` in the same cycle as `eom` is used for that message.
- R10: An `eom` with no `hdr_valid` since the last `sof_valid` or `eom` produces no pulse of any kind.
- R11: After reset, `rx_active`, `ack_req`, `deliver_valid`, `ack_seen` and `ack_seen_id` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof_valid | input | 1 | Start-of-packet ordered set detected |
| sof_type | input | 3 | Detected ordered-set code |
| hdr_valid | input | 1 | Header word valid |
| hdr_data | input | 16 | Received message header |
| eom | input | 1 | End of message strobe |
| eom_err | input | 1 | Receive error flag, qualified by eom |
| cfg_power_role | input | 1 | Local power role for SOP replies |
| cfg_data_role | input | 1 | Local data role for SOP replies |
| cfg_prime_en | input | 1 | Accept non-SOP ordered-set kinds |
| cfg_bist_mode | input | 1 | Test mode: acknowledge but do not deliver |
| rx_active | output | 1 | Reception in progress |
| deliver_valid | output | 1 | Message delivered upward (pulse) |
| deliver_type | output | 3 | Ordered-set code of the delivered message |
| deliver_hdr | output | 16 | Header of the delivered message |
| ack_req | output | 1 | Request to send an acknowledge (pulse) |
| ack_hdr | output | 16 | Acknowledge header to send |
| ack_type | output | 3 | Ordered-set code for the acknowledge |
| ack_len | output | 4 | Acknowledge length in bytes |
| ack_seen | output | 1 | Acknowledge received (pulse) |
| ack_seen_id | output | 3 | Message ID of the last received acknowledge |

## Verification
Several properties are checked on every cycle:
- the fixed fields and role-bit zeroing of every reply header;
- the fixed reply length;
- the mutual exclusion between replying and seeing an acknowledge;
- the rule that delivery always comes with a reply;
- suppression of delivery in test mode;
- silence after an errored end of message;
- the hold of the stored acknowledge ID;
- the busy flag's response to the start and end strobes.

Other behaviours only the bench's scenarios can show:
- that the echoed ID and revision match the header actually received;
- that non-SOP kinds are rejected when disabled;
- that near-miss headers are not taken for acknowledges;
- that an end of message without a header is dropped.

// File: rtl/pd_rx_pkg.sv
package pd_rx_pkg;

   localparam int PD_HDR_W = 16;
   localparam int PD_ID_W  = 3;
   localparam logic [4:0] PD_ACK_MTYPE = 5'b00001;

   typedef struct packed {
      logic       ext;
      logic [2:0] obj_cnt;
      logic [2:0] msg_id;
      logic       prole;
      logic [1:0] rev;
      logic       drole;
      logic [4:0] mtype;
   } pd_hdr_t;

endpackage

// File: rtl/pd_rx_capture.sv
module pd_rx_capture #(
   parameter int SOP_W = 3,
   parameter int HDR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof_valid,
   input  logic [SOP_W-1:0] sof_type,
   input  logic             hdr_valid,
   input  logic [HDR_W-1:0] hdr_data,
   input  logic             eom,
   output logic             rx_active,
   output logic [SOP_W-1:0] cur_type,
   output logic [HDR_W-1:0] cur_hdr,
   output logic             cur_have
);

   logic [SOP_W-1:0] type_q;
   logic [HDR_W-1:0] hdr_q;
   logic             have_q;
   logic             active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q   <= '0;
         hdr_q    <= '0;
         have_q   <= 1'b0;
         active_q <= 1'b0;
      end else begin
         if (sof_valid)
            type_q <= sof_type;
         if (hdr_valid)
            hdr_q <= hdr_data;
         if (sof_valid || eom)
            have_q <= 1'b0;
         else if (hdr_valid)
            have_q <= 1'b1;
         if (sof_valid)
            active_q <= 1'b1;
         else if (eom)
            active_q <= 1'b0;
      end
   end

   assign rx_active = active_q;
   assign cur_type  = type_q;
   assign cur_hdr   = hdr_valid ? hdr_data : hdr_q;
   assign cur_have  = hdr_valid | have_q;

endmodule

// File: rtl/pd_hdr_decode.sv
module pd_hdr_decode
   import pd_rx_pkg::*;
(
   input  logic [PD_HDR_W-1:0] hdr,
   output pd_hdr_t             fld,
   output logic                is_ack
);

   always_comb begin
      fld    = pd_hdr_t'(hdr);
      is_ack = (fld.ext == 1'b0) && (fld.obj_cnt == 3'd0) &&
               (fld.mtype == PD_ACK_MTYPE);
   end

endmodule

// File: rtl/pd_ack_builder.sv
module pd_ack_builder
   import pd_rx_pkg::*;
#(
   parameter int SOP_W = 3,
   parameter int PLAIN = 0
) (
   input  pd_hdr_t             rx_fld,
   input  logic [SOP_W-1:0]    rx_type,
   input  logic                cfg_power_role,
   input  logic                cfg_data_role,
   output logic [PD_HDR_W-1:0] ack_hdr
);

   localparam logic [SOP_W-1:0] PLAIN_CODE = SOP_W'(PLAIN);

   pd_hdr_t reply;
   logic    plain_sop;

   always_comb begin
      plain_sop     = (rx_type == PLAIN_CODE);
      reply         = '0;
      reply.ext     = 1'b0;
      reply.obj_cnt = 3'd0;
      reply.msg_id  = rx_fld.msg_id;
      reply.rev     = rx_fld.rev;
      reply.mtype   = PD_ACK_MTYPE;
      reply.prole   = plain_sop ? cfg_power_role : 1'b0;
      reply.drole   = plain_sop ? cfg_data_role  : 1'b0;
      ack_hdr       = PD_HDR_W'(reply);
   end

endmodule

// File: rtl/pd_rx_dispatch.sv
module pd_rx_dispatch
   import pd_rx_pkg::*;
#(
   parameter int SOP_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                eom,
   input  logic                eom_err,
   input  logic                have_hdr,
   input  logic                is_ack,
   input  logic                accept,
   input  logic                bist,
   input  logic [SOP_W-1:0]    rx_type,
   input  logic [PD_HDR_W-1:0] rx_hdr,
   input  logic [PD_HDR_W-1:0] reply_hdr,
   output logic                deliver_valid,
   output logic [SOP_W-1:0]    deliver_type,
   output logic [PD_HDR_W-1:0] deliver_hdr,
   output logic                ack_req,
   output logic [PD_HDR_W-1:0] ack_hdr,
   output logic [SOP_W-1:0]    ack_type,
   output logic                ack_seen,
   output logic [PD_ID_W-1:0]  ack_seen_id
);

   logic clean, take_ack, take_msg;

   always_comb begin
      clean    = eom && !eom_err && have_hdr;
      take_ack = clean && is_ack;
      take_msg = clean && !is_ack && accept;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         deliver_valid <= 1'b0;
         deliver_type  <= '0;
         deliver_hdr   <= '0;
         ack_req       <= 1'b0;
         ack_hdr       <= '0;
         ack_type      <= '0;
         ack_seen      <= 1'b0;
         ack_seen_id   <= '0;
      end else begin
         ack_seen      <= take_ack;
         ack_req       <= take_msg;
         deliver_valid <= take_msg && !bist;
         if (take_ack)
            ack_seen_id <= rx_hdr[11:9];
         if (take_msg) begin
            ack_hdr      <= reply_hdr;
            ack_type     <= rx_type;
            deliver_type <= rx_type;
            deliver_hdr  <= rx_hdr;
         end
      end
   end

endmodule

// File: rtl/pd_rx_ack_filter.sv
module pd_rx_ack_filter
   import pd_rx_pkg::*;
#(
   parameter int SOP_W     = 3,
   parameter int PLAIN     = 0,
   parameter int LEN_W     = 4,
   parameter int ACK_BYTES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sof_valid,
   input  logic [SOP_W-1:0]    sof_type,
   input  logic                hdr_valid,
   input  logic [PD_HDR_W-1:0] hdr_data,
   input  logic                eom,
   input  logic                eom_err,
   input  logic                cfg_power_role,
   input  logic                cfg_data_role,
   input  logic                cfg_prime_en,
   input  logic                cfg_bist_mode,
   output logic                rx_active,
   output logic                deliver_valid,
   output logic [SOP_W-1:0]    deliver_type,
   output logic [PD_HDR_W-1:0] deliver_hdr,
   output logic                ack_req,
   output logic [PD_HDR_W-1:0] ack_hdr,
   output logic [SOP_W-1:0]    ack_type,
   output logic [LEN_W-1:0]    ack_len,
   output logic                ack_seen,
   output logic [PD_ID_W-1:0]  ack_seen_id
);

   localparam int NKIND = 1 << SOP_W;

   if (SOP_W < 3) begin : g_bad_sop_w
      $error("SOP_W must cover five ordered-set kinds");
   end
   if (PLAIN >= NKIND) begin : g_bad_plain
      $error("PLAIN code out of range");
   end
   if ((1 << LEN_W) <= ACK_BYTES) begin : g_bad_len
      $error("LEN_W too narrow for ACK_BYTES");
   end

   logic [SOP_W-1:0]    cur_type;
   logic [PD_HDR_W-1:0] cur_hdr;
   logic                cur_have;
   pd_hdr_t             fld;
   logic                is_ack;
   logic [PD_HDR_W-1:0] reply_hdr;
   logic [NKIND-1:0]    accept_mask;
   logic                accept;

   pd_rx_capture #(.SOP_W(SOP_W), .HDR_W(PD_HDR_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof_valid (sof_valid),
      .sof_type  (sof_type),
      .hdr_valid (hdr_valid),
      .hdr_data  (hdr_data),
      .eom       (eom),
      .rx_active (rx_active),
      .cur_type  (cur_type),
      .cur_hdr   (cur_hdr),
      .cur_have  (cur_have)
   );

   pd_hdr_decode u_dec (
      .hdr    (cur_hdr),
      .fld    (fld),
      .is_ack (is_ack)
   );

   pd_ack_builder #(.SOP_W(SOP_W), .PLAIN(PLAIN)) u_bld (
      .rx_fld         (fld),
      .rx_type        (cur_type),
      .cfg_power_role (cfg_power_role),
      .cfg_data_role  (cfg_data_role),
      .ack_hdr        (reply_hdr)
   );

   for (genvar k = 0; k < NKIND; k++) begin : g_accept
      if (k == PLAIN) begin : g_plain
         assign accept_mask[k] = 1'b1;
      end else begin : g_other
         assign accept_mask[k] = cfg_prime_en;
      end
   end

   assign accept  = accept_mask[cur_type];
   assign ack_len = LEN_W'(ACK_BYTES);

   pd_rx_dispatch #(.SOP_W(SOP_W)) u_dsp (
      .clk           (clk),
      .rst_n         (rst_n),
      .eom           (eom),
      .eom_err       (eom_err),
      .have_hdr      (cur_have),
      .is_ack        (is_ack),
      .accept        (accept),
      .bist          (cfg_bist_mode),
      .rx_type       (cur_type),
      .rx_hdr        (cur_hdr),
      .reply_hdr     (reply_hdr),
      .deliver_valid (deliver_valid),
      .deliver_type  (deliver_type),
      .deliver_hdr   (deliver_hdr),
      .ack_req       (ack_req),
      .ack_hdr       (ack_hdr),
      .ack_type      (ack_type),
      .ack_seen      (ack_seen),
      .ack_seen_id   (ack_seen_id)
   );

endmodule

// File: rtl/pd_rx_ack_filter_chk.sv
module pd_rx_ack_filter_chk
   import pd_rx_pkg::*;
#(
   parameter int SOP_W     = 3,
   parameter int PLAIN     = 0,
   parameter int LEN_W     = 4,
   parameter int ACK_BYTES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sof_valid,
   input logic                eom,
   input logic                eom_err,
   input logic                cfg_bist_mode,
   input logic                rx_active,
   input logic                deliver_valid,
   input logic                ack_req,
   input logic [PD_HDR_W-1:0] ack_hdr,
   input logic [SOP_W-1:0]    ack_type,
   input logic [LEN_W-1:0]    ack_len,
   input logic                ack_seen,
   input logic [PD_ID_W-1:0]  ack_seen_id
);

   a_r1_no_reply_to_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_seen && ack_req));

   a_r1_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_seen |-> $stable(ack_seen_id));

   a_r2_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |-> (ack_hdr[15:12] == 4'd0 && ack_hdr[4:0] == PD_ACK_MTYPE));

   a_r3_roles_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && ack_type != SOP_W'(PLAIN)) |-> (!ack_hdr[8] && !ack_hdr[5]));

   a_r4_len: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |-> ack_len == LEN_W'(ACK_BYTES));

   a_r5_deliver_acked: assert property (@(posedge clk) disable iff (!rst_n)
      deliver_valid |-> ack_req);

   a_r6_bist_no_deliver: assert property (@(posedge clk) disable iff (!rst_n)
      (eom && cfg_bist_mode) |=> !deliver_valid);

   a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (eom && eom_err) |=> (!ack_req && !deliver_valid && !ack_seen));

   a_r8_active_set: assert property (@(posedge clk) disable iff (!rst_n)
      sof_valid |=> rx_active);

   a_r8_active_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (eom && !sof_valid) |=> !rx_active);

endmodule

bind pd_rx_ack_filter pd_rx_ack_filter_chk #(
   .SOP_W(SOP_W), .PLAIN(PLAIN), .LEN_W(LEN_W), .ACK_BYTES(ACK_BYTES)
) u_chk (.*);

// File: tb/pd_rx_ack_filter_tb.sv
module pd_rx_ack_filter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof_valid = 0, hdr_valid = 0, eom = 0, eom_err = 0;
   logic [2:0]  sof_type = 0;
   logic [15:0] hdr_data = 0;
   logic        cfg_power_role = 0, cfg_data_role = 0, cfg_prime_en = 0, cfg_bist_mode = 0;
   logic        rx_active, deliver_valid, ack_req, ack_seen;
   logic [2:0]  deliver_type, ack_type, ack_seen_id;
   logic [15:0] deliver_hdr, ack_hdr;
   logic [3:0]  ack_len;

   int n_cmp = 0, n_bad = 0;
   int n_ack = 0, n_del = 0, n_seen = 0;

   always #5 clk = ~clk;

   pd_rx_ack_filter u_dut (
      .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid), .sof_type(sof_type),
      .hdr_valid(hdr_valid), .hdr_data(hdr_data), .eom(eom), .eom_err(eom_err),
      .cfg_power_role(cfg_power_role), .cfg_data_role(cfg_data_role),
      .cfg_prime_en(cfg_prime_en), .cfg_bist_mode(cfg_bist_mode),
      .rx_active(rx_active), .deliver_valid(deliver_valid), .deliver_type(deliver_type),
      .deliver_hdr(deliver_hdr), .ack_req(ack_req), .ack_hdr(ack_hdr),
      .ack_type(ack_type), .ack_len(ack_len), .ack_seen(ack_seen),
      .ack_seen_id(ack_seen_id)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   int   m_type = 0, m_hdr = 0;
   bit   m_have = 0;
   bit   e_active = 0, e_del = 0, e_ack = 0, e_seen = 0;
   int   e_del_type = 0, e_del_hdr = 0, e_ack_hdr = 0, e_ack_type = 0, e_seen_id = 0;

   always @(posedge clk) begin
      int  h;
      bit  have, isack, plain;
      if (!rst_n) begin
         m_type = 0; m_hdr = 0; m_have = 0;
         e_active <= 0; e_del <= 0; e_ack <= 0; e_seen <= 0; e_seen_id <= 0;
      end else begin
         h     = hdr_valid ? int'(hdr_data) : m_hdr;
         have  = hdr_valid || m_have;
         e_del <= 0; e_ack <= 0; e_seen <= 0;
         if (eom && !eom_err && have) begin
            isack = ((h >> 15) & 1) == 0 && ((h >> 12) & 7) == 0 && (h & 31) == 1;
            plain = (m_type == 0);
            if (isack) begin
               e_seen    <= 1;
               e_seen_id <= (h >> 9) & 7;
            end else if (plain || cfg_prime_en) begin
               e_ack      <= 1;
               e_ack_type <= m_type;
               e_ack_hdr  <= (((h >> 9) & 7) << 9) | (((h >> 6) & 3) << 6) | 1
                             | ((plain && cfg_power_role) ? 256 : 0)
                             | ((plain && cfg_data_role) ? 32 : 0);
               if (!cfg_bist_mode) begin
                  e_del      <= 1;
                  e_del_type <= m_type;
                  e_del_hdr  <= h;
               end
            end
         end
         if (hdr_valid) m_hdr = int'(hdr_data);
         if (sof_valid) m_type = int'(sof_type);
         if (sof_valid || eom) m_have = 0;
         else if (hdr_valid) m_have = 1;
         if (sof_valid) e_active <= 1;
         else if (eom) e_active <= 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8 rx_active", rx_active, e_active);
         chk("R9 ack_req pulse", ack_req, e_ack);
         chk("R5 deliver pulse", deliver_valid, e_del);
         chk("R1 ack_seen pulse", ack_seen, e_seen);
         chk("R1 ack_seen_id", ack_seen_id, e_seen_id);
         if (ack_req) begin
            chk("R2 ack_hdr", ack_hdr, e_ack_hdr);
            chk("R4 ack_type", ack_type, e_ack_type);
            chk("R4 ack_len", ack_len, 2);
         end
         if (deliver_valid) begin
            chk("R5 deliver_hdr", deliver_hdr, e_del_hdr);
            chk("R5 deliver_type", deliver_type, e_del_type);
         end
         n_ack  += ack_req;
         n_del  += deliver_valid;
         n_seen += ack_seen;
      end
   end

   function automatic logic [15:0] mk(input bit ext, input int cnt, input int id,
                                      input int rev, input int mt);
      return {ext, cnt[2:0], id[2:0], 1'b0, rev[1:0], 1'b0, mt[4:0]};
   endfunction

   // mode: 0 normal, 1 header with eom, 2 no header
   task automatic pkt(input int t, input logic [15:0] h, input bit err, input int mode);
      @(negedge clk); sof_valid = 1; sof_type = t[2:0];
      @(negedge clk); sof_valid = 0;
      if (mode == 0) begin
         hdr_valid = 1; hdr_data = h;
         @(negedge clk); hdr_valid = 0;
      end
      @(negedge clk);
      eom = 1; eom_err = err;
      if (mode == 1) begin hdr_valid = 1; hdr_data = h; end
      @(negedge clk); eom = 0; eom_err = 0; hdr_valid = 0;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int a0, d0, s0;
      repeat (3) @(negedge clk);
      chk("R11 reset rx_active", rx_active, 0);
      chk("R11 reset ack_req", ack_req, 0);
      chk("R11 reset deliver", deliver_valid, 0);
      chk("R11 reset ack_seen", ack_seen, 0);
      chk("R11 reset seen_id", ack_seen_id, 0);
      rst_n = 1;
      cfg_power_role = 1; cfg_data_role = 1;

      a0 = n_ack; d0 = n_del;
      pkt(0, mk(0, 2, 3, 2, 2), 0, 0);
      chk("R5 SOP accepted ack", n_ack - a0, 1);
      chk("R5 SOP delivered", n_del - d0, 1);
      chk("R3 SOP roles", {ack_hdr[8], ack_hdr[5]}, 3);

      a0 = n_ack; d0 = n_del;
      pkt(1, mk(0, 0, 4, 1, 3), 0, 0);
      chk("R5 prime rejected ack", n_ack - a0, 0);
      chk("R5 prime rejected deliver", n_del - d0, 0);

      cfg_prime_en = 1;
      a0 = n_ack;
      pkt(1, mk(0, 0, 5, 1, 3), 0, 0);
      chk("R3 prime ack issued", n_ack - a0, 1);
      chk("R3 prime roles zero", {ack_hdr[8], ack_hdr[5]}, 0);
      chk("R4 prime ack_type", ack_type, 1);
      a0 = n_ack;
      pkt(4, mk(0, 1, 7, 2, 4), 0, 0);
      chk("R4 dbg ack_type", ack_type, 4);
      chk("R2 echo id", ack_hdr[11:9], 7);

      a0 = n_ack; s0 = n_seen;
      pkt(0, mk(0, 0, 6, 2, 1), 0, 0);
      chk("R1 goodcrc seen", n_seen - s0, 1);
      chk("R1 goodcrc no reply", n_ack - a0, 0);
      chk("R1 goodcrc id", ack_seen_id, 6);

      s0 = n_seen; a0 = n_ack;
      pkt(0, mk(0, 1, 2, 2, 1), 0, 0);
      chk("R1 count nonzero not ack", n_seen - s0, 0);
      chk("R1 count nonzero replied", n_ack - a0, 1);
      s0 = n_seen;
      pkt(0, mk(1, 0, 2, 2, 1), 0, 0);
      chk("R1 extended not ack", n_seen - s0, 0);

      cfg_bist_mode = 1; a0 = n_ack; d0 = n_del;
      pkt(0, mk(0, 0, 1, 1, 6), 0, 0);
      chk("R6 bist ack", n_ack - a0, 1);
      chk("R6 bist no deliver", n_del - d0, 0);
      cfg_bist_mode = 0;

      a0 = n_ack; d0 = n_del; s0 = n_seen;
      pkt(0, mk(0, 0, 3, 1, 6), 1, 0);
      pkt(0, mk(0, 0, 3, 1, 1), 1, 0);
      chk("R7 error no ack", n_ack - a0, 0);
      chk("R7 error no deliver", n_del - d0, 0);
      chk("R7 error no seen", n_seen - s0, 0);
      chk("R7 id unchanged", ack_seen_id, 6);

      a0 = n_ack; s0 = n_seen;
      pkt(0, mk(0, 0, 3, 1, 6), 0, 2);
      chk("R10 no header no ack", n_ack - a0, 0);
      chk("R10 no header no seen", n_seen - s0, 0);

      a0 = n_ack;
      pkt(0, mk(0, 3, 4, 2, 7), 0, 1);
      chk("R9 same-cycle header ack", n_ack - a0, 1);
      chk("R9 same-cycle header id", ack_hdr[11:9], 4);

      for (int i = 0; i < 400; i++) begin
         int t, mt;
         @(negedge clk);
         cfg_prime_en   = $urandom_range(0, 1);
         cfg_bist_mode  = ($urandom_range(0, 3) == 0);
         cfg_power_role = $urandom_range(0, 1);
         cfg_data_role  = $urandom_range(0, 1);
         t  = $urandom_range(0, 5);
         mt = ($urandom_range(0, 2) == 0) ? 1 : $urandom_range(0, 31);
         pkt(t, {$urandom_range(0, 1) == 0 ? 1'b0 : 1'b1,
                 $urandom_range(0, 1) == 0 ? 3'd0 : 3'($urandom_range(0, 7)),
                 3'($urandom_range(0, 7)), 1'b1, 2'($urandom_range(0, 3)),
                 1'b1, mt[4:0]},
             ($urandom_range(0, 7) == 0), $urandom_range(0, 2));
      end

      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule